// File: doc/BRIEF.md
# Chained FIFO-to-Memory DMA Receiver

This block empties a 32-bit inter-processor FIFO into memory, one 128-bit quadword at a time. Software loads a destination address, a quadword count and the mode bits, then sets the start bit. In normal mode the channel copies exactly that many quadwords and then stops. In chain mode the destination descriptors arrive in-band through the same FIFO. Whenever the remaining count is zero, the channel pulls a four-word tag out of the FIFO. That tag supplies a new address, a new count, an identifier and an interrupt flag. The chain stops on a terminating tag, or on a flagged tag when tag interrupts are enabled.

On completion the channel goes idle, clears its start bit and emits a one-cycle interrupt. Clearing the start bit by a control write abandons the transfer silently. The FIFO presents its four head words in parallel and pops all four on one pop strobe.

Top module: `fifo_chain_dma`

## Requirements
- R1: After reset the channel is idle: `busy`, `irq`, `mem_we` and `fifo_pop` are all 0.
- R2: A control write with `ctrl_wdata[0]`=1 (start) loads `ctrl_addr` and `ctrl_qwc`, and takes chain mode from `ctrl_wdata[1]` and tag-interrupt enable from `ctrl_wdata[2]`. It is accepted only while idle. Such a write while busy changes nothing.
- R3: A quadword moves only when the count is nonzero and `fifo_count` is at least 4. The move asserts `mem_we` and `fifo_pop` for one cycle, with FIFO head word k in `mem_wdata[32k+31:32k]`, and decrements the count.
- R4: Each quadword written advances the destination address by 16.
- R5: In chain mode, with count zero, no end pending and at least 4 words queued, one pop consumes a tag. Tag word 1 becomes the address. Bits 15:0 of tag word 0 are the count, bits 30:28 the ID and bit 31 the IRQ flag.
- R6: A tag with ID 7 ends the chain after its data. Other IDs (such as 0 and 1) let the chain continue, and words behind an ending tag stay in the FIFO.
- R7: A tag with its IRQ flag set ends the chain after its data only when tag-interrupt enable is 1.
- R8: When the count is zero in normal mode, or with the end flag set, the channel clears `busy` and raises `irq` for exactly one cycle.
- R9: A control write with `ctrl_wdata[0]`=0 drops `busy` in the next cycle, raises no interrupt and moves no further data.
- R10: An ending tag with count zero completes the chain with no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | {tag-irq enable, chain mode, start} |
| ctrl_addr | input | 32 | Initial destination byte address |
| ctrl_qwc | input | 16 | Initial quadword count |
| fifo_count | input | 8 | Words currently held in the FIFO |
| fifo_q | input | 128 | Four head words of the FIFO, oldest in bits 31:0 |
| fifo_pop | output | 1 | Remove four words from the FIFO |
| mem_we | output | 1 | Memory quadword write strobe |
| mem_addr | output | 32 | Memory write byte address |
| mem_wdata | output | 128 | Memory write data |
| busy | output | 1 | Channel active (start bit) |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench feeds the FIFO fewer than four words and checks that nothing moves. A design that moved partial quadwords would write garbage and pop words it does not have. It also follows a flagged tag with tag interrupts disabled, then an ID 0 tag, then an ending tag, and checks that words queued behind the end remain unread. A design that decoded the ID or IRQ bit wrongly would stop early or swallow the next tag. A start issued mid-transfer, an abort, and an ending tag of zero length complete the set. A design that got these wrong would redirect the active transfer, emit a spurious interrupt, or write a quadword that was never announced.

// File: rtl/fifo_chain_dma.sv
module fifo_chain_dma #(
  parameter int AW = 32,
  parameter int QW = 16,
  parameter int CW = 8,
  parameter int WW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic [2:0]      ctrl_wdata,
  input  logic [AW-1:0]   ctrl_addr,
  input  logic [QW-1:0]   ctrl_qwc,
  input  logic [CW-1:0]   fifo_count,
  input  logic [4*WW-1:0] fifo_q,
  output logic            fifo_pop,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [4*WW-1:0] mem_wdata,
  output logic            busy,
  output logic            irq
);
  localparam logic [2:0] ID_END = 3'd7;
  localparam int QBYTES = WW / 2;

  logic          chain, tie, endf;
  logic [QW-1:0] qwc;
  logic [AW-1:0] addr;

  wire kill     = ctrl_we && !ctrl_wdata[0];
  wire have4    = fifo_count >= CW'(4);
  wire cnt_zero = qwc == '0;
  wire finish   = busy && cnt_zero && (!chain || endf) && !kill;
  wire take_tag = busy && cnt_zero && chain && !endf && have4 && !kill;
  wire move     = busy && !cnt_zero && have4 && !kill;

  wire [2:0] tag_id  = fifo_q[30:28];
  wire       tag_irq = fifo_q[31];

  assign fifo_pop  = take_tag || move;
  assign mem_we    = move;
  assign mem_addr  = addr;
  assign mem_wdata = fifo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; irq <= 1'b0; chain <= 1'b0; tie <= 1'b0;
      endf <= 1'b0; qwc <= '0; addr <= '0;
    end else begin
      irq <= 1'b0;
      if (kill) begin
        busy <= 1'b0;
        endf <= 1'b0;
      end else if (ctrl_we && !busy) begin
        busy  <= 1'b1;
        chain <= ctrl_wdata[1];
        tie   <= ctrl_wdata[2];
        qwc   <= ctrl_qwc;
        addr  <= ctrl_addr;
        endf  <= 1'b0;
      end else if (finish) begin
        busy <= 1'b0;
        endf <= 1'b0;
        irq  <= 1'b1;
      end else if (take_tag) begin
        qwc  <= fifo_q[QW-1:0];
        addr <= fifo_q[WW+AW-1:WW];
        endf <= (tag_id == ID_END) || (tie && tag_irq);
      end else if (move) begin
        qwc  <= qwc - QW'(1);
        addr <= addr + AW'(QBYTES);
      end
    end
  end

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy && !mem_we);
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_we) && mem_we |-> mem_addr == $past(mem_addr) + AW'(QBYTES));
  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && !ctrl_wdata[0] |=> !busy && !irq);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we && !fifo_pop);
  // R3
  pop_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_count >= CW'(4));
endmodule

// File: tb/fifo_chain_dma_tb_top.sv
`timescale 1ns/1ps
module fifo_chain_dma_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0;
  logic [2:0] ctrl_wdata = '0;
  logic [31:0] ctrl_addr = '0;
  logic [15:0] ctrl_qwc = '0;
  logic [7:0] fifo_count;
  logic [127:0] fifo_q;
  logic fifo_pop, mem_we, busy, irq;
  logic [31:0] mem_addr;
  logic [127:0] mem_wdata;

  always #2.5 clk = ~clk;

  fifo_chain_dma dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_addr(ctrl_addr), .ctrl_qwc(ctrl_qwc), .fifo_count(fifo_count),
    .fifo_q(fifo_q), .fifo_pop(fifo_pop), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .irq(irq));

  logic [31:0] fq [0:255];
  int head = 0, tail = 0;
  assign fifo_count = 8'(tail - head);
  assign fifo_q = {fq[8'(head+3)], fq[8'(head+2)], fq[8'(head+1)], fq[8'(head)]};
  always @(posedge clk) if (fifo_pop) head <= head + 4;

  int vectors = 0, fails = 0, irq_cnt = 0;
  logic prev_irq = 1'b0;
  logic [159:0] exp_q[$];
  logic [31:0] seed = 32'hA5000000;

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected write", {mem_addr, mem_wdata}, 0);
        else begin
          logic [159:0] e;
          e = exp_q.pop_front();
          chk({mem_addr, mem_wdata} === e, "R3/R4 write", {mem_addr, mem_wdata}, e);
        end
      end
      if (irq) begin
        irq_cnt++;
        if (prev_irq) chk(0, "R8 irq width", 2, 1);
      end
      prev_irq = irq;
    end
  end

  task automatic push(input logic [31:0] w);
    fq[8'(tail)] = w;
    tail = tail + 1;
  endtask

  task automatic push_qw(input logic [31:0] a, input bit expect_it);
    logic [127:0] d;
    for (int k = 0; k < 4; k++) begin
      d[32*k +: 32] = seed;
      push(seed);
      seed = seed + 32'h101;
    end
    if (expect_it) exp_q.push_back({a, d});
  endtask

  task automatic push_tag(input logic [31:0] w0, input logic [31:0] w1);
    push(w0); push(w1); push(32'hDEAD0002); push(32'hDEAD0003);
  endtask

  task automatic ctrl(input logic [2:0] wd, input logic [31:0] a, input logic [15:0] q);
    ctrl_wdata = wd; ctrl_addr = a; ctrl_qwc = q; ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic flush();
    head = 0; tail = 0;
  endtask

  bit finished = 0;
  int base;

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !mem_we && !fifo_pop, "R1 reset idle", {busy, irq, mem_we, fifo_pop}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3, R4, R8: normal mode, starved FIFO
    ctrl(3'b001, 32'h1000, 16'd3);
    push(32'h1); push(32'h2); push(32'h3);
    repeat (5) @(negedge clk);
    chk(fifo_count == 3 && busy, "R3 partial quadword held", fifo_count, 3);
    flush();
    base = irq_cnt;
    push_qw(32'h1000, 1); push_qw(32'h1010, 1);
    repeat (3) @(negedge clk);
    push_qw(32'h1020, 1);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R4 normal writes done", exp_q.size(), 0);
    chk(!busy && irq_cnt == base + 1, "R8 normal completion", {busy, 8'(irq_cnt - base)}, 1);

    // R2: start while busy ignored
    flush();
    ctrl(3'b001, 32'h4000, 16'd2);
    ctrl(3'b011, 32'h9000, 16'd5);
    base = irq_cnt;
    push_qw(32'h4000, 1); push_qw(32'h4010, 1);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0 && !busy, "R2 restart ignored", exp_q.size(), 0);
    chk(irq_cnt == base + 1, "R2 single irq", irq_cnt - base, 1);

    // R5, R7: chain, tag irq enable set, tag 0x90000002
    flush();
    ctrl(3'b111, 32'h0, 16'd0);
    base = irq_cnt;
    push_tag(32'h90000002, 32'h2000);
    push_qw(32'h2000, 1); push_qw(32'h2010, 1);
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R5 chain tag data", exp_q.size(), 0);
    chk(!busy && irq_cnt == base + 1, "R7 irq flag ends chain", {busy, 8'(irq_cnt - base)}, 1);

    // R6, R7: tie off, irq tag continues, id 0 continues, id 7 ends
    flush();
    ctrl(3'b011, 32'h0, 16'd0);
    base = irq_cnt;
    push_tag(32'h90000001, 32'h3000);
    push_qw(32'h3000, 1);
    repeat (4) @(negedge clk);
    chk(busy && irq_cnt == base, "R7 irq flag ignored without enable", busy, 1);
    push_tag(32'h00000001, 32'h3100);
    push_qw(32'h3100, 1);
    repeat (4) @(negedge clk);
    chk(busy && irq_cnt == base, "R6 id 0 continues", busy, 1);
    push_tag(32'h70000002, 32'h3200);
    push_qw(32'h3200, 1); push_qw(32'h3210, 1);
    push_qw(32'h0, 0);
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R6 chain data", exp_q.size(), 0);
    chk(!busy && irq_cnt == base + 1, "R6 end id completes", {busy, 8'(irq_cnt - base)}, 1);
    chk(fifo_count == 4, "R6 words after end untouched", fifo_count, 4);

    // R10: zero-length end tag
    flush();
    ctrl(3'b011, 32'h0, 16'd0);
    base = irq_cnt;
    push_tag(32'h70000000, 32'h6000);
    repeat (5) @(negedge clk);
    chk(!busy && irq_cnt == base + 1, "R10 empty end tag", {busy, 8'(irq_cnt - base)}, 1);
    chk(fifo_count == 0, "R10 tag consumed", fifo_count, 0);

    // R9: abort
    flush();
    ctrl(3'b001, 32'h5000, 16'd4);
    base = irq_cnt;
    push_qw(32'h5000, 1);
    repeat (3) @(negedge clk);
    ctrl(3'b000, 32'h0, 16'd0);
    chk(!busy, "R9 abort drops busy", busy, 0);
    push_qw(32'h5010, 0);
    repeat (5) @(negedge clk);
    chk(irq_cnt == base, "R9 no irq on abort", irq_cnt - base, 0);
    chk(fifo_count == 4 && exp_q.size() == 0, "R9 no data after abort", fifo_count, 4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule